// File: doc/BRIEF.md
# Selectable Frame-Sync Divider Generator

This block is the digital back end of a clock rate adapter that converts between the T-carrier and E-carrier rates. It runs on a high-rate synthesized clock that a PLL outside the block provides. From that clock it derives a carrier-rate clock with a near-even duty cycle. It also derives a frame pulse that repeats at 8 kHz and stays one carrier period wide. A mode input picks the conversion direction. A build-time variant parameter picks which high-rate clock and carrier rate the T1-to-E1 direction uses.

An optional external frame-sync input can realign both dividers. It is sampled on the rising edge of the input-rate clock and carried into the high-rate domain through a two-flop synchronizer. Each sampled rising edge restarts the carrier divider and the frame counter at phase zero. The sync may run at 8 kHz or at a sub-rate of it. When it sits at a steady level, both dividers free-run. A change of the mode input also restarts both counters, so no frame is cut short or runs past its end.

Top module: `frsync_gen`

## Requirements
- R1: While rst_n is low, and on the clk_hi cycle that follows its release, both counters stand at phase zero, with clkout1 high and syncout high.
- R2: Mode encoding. sel=1 (E1 to T1) gives a divide ratio of 4 and a frame of 193 carrier cycles for every variant. With sel=0 (T1 to E1), the ratio and frame depend on VARIANT: VARIANT=0 gives ratio 3 and a 256-cycle frame, VARIANT=1 gives ratio 4 and a 256-cycle frame, and VARIANT=2 gives ratio 2 and a 512-cycle frame.
- R3: One carrier period is ratio clk_hi cycles long. clkout1 is high for the first ceil(ratio/2) cycles of the period and low for the rest.
- R4: syncout rises at the start of a carrier period. It stays high for exactly ratio clk_hi cycles, which is one carrier period. Its rising edges are ratio*frame clk_hi cycles apart, which is the 8 kHz frame.
- R5: syncin is sampled on each rising edge of clk_in. Take a clk_in edge whose sample is 1 when the previous sample was 0. On the third clk_hi rising edge after that clk_in edge, both counters return to phase zero, so clkout1 and syncout both go high and start a fresh frame.
- R6: A syncin held at a steady high or low level causes no realignment. The dividers then keep their free-running period.
- R7: A sub-rate syncin whose rising edges land on frame boundaries, such as one edge every two frames, leaves the frame period unchanged.
- R8: A sel value that differs from the value at the previous clk_hi edge restarts both counters at phase zero on that edge. The previous value is taken as 0 after reset.
- R9: Whatever phase a restart interrupts, the divider never exceeds ratio-1 and the frame counter never exceeds frame-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_hi | input | 1 | High-rate synthesized clock; all counters run on it |
| clk_in | input | 1 | Input-rate clock; syncin is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| sel | input | 1 | Conversion select: 0 for T1 to E1, 1 for E1 to T1 |
| syncin | input | 1 | Optional external frame-sync pulse |
| clkout1 | output | 1 | Carrier-rate clock derived from clk_hi |
| syncout | output | 1 | 8 kHz frame pulse, one carrier period wide |

## Verification
The assertions assume that sel changes only between clk_hi rising edges. They also assume each syncin pulse is held for at least one full clk_in period, with a low sample between pulses. Finally, clk_in must be slow enough that a sampled level lasts several clk_hi cycles, so each sync edge crosses as a single restart pulse. The stimulus runs clk_in at one quarter of the clk_hi rate, with its rising edges halfway between clk_hi rising edges. It drives syncin only on clk_in falling edges and changes sel only on clk_hi falling edges, so the synchronizer latency is fixed and the expected restart cycle is exact.

// File: rtl/frsync_pkg.sv
package frsync_pkg;

  // Largest divide ratio and frame length over all modes and variants
  localparam int FS_MAX_RATIO = 4;
  localparam int FS_MAX_FRAME = 512;
  localparam int FS_DIV_W     = $clog2(FS_MAX_RATIO + 1);
  localparam int FS_FRM_W     = $clog2(FS_MAX_FRAME);

  typedef struct packed {
    logic [FS_DIV_W-1:0] div_last;  // ratio - 1
    logic [FS_DIV_W-1:0] high_len;  // high cycles of the carrier clock
    logic [FS_FRM_W-1:0] frm_last;  // frame length - 1
  } fs_mode_t;

  // Divide ratio from the high-rate clock down to the carrier clock
  function automatic int fs_ratio(input int variant, input logic sel);
    if (sel) return 4;
    case (variant)
      0:       return 3;
      1:       return 4;
      default: return 2;
    endcase
  endfunction

  // Carrier cycles in one 8 kHz frame
  function automatic int fs_frame_len(input int variant, input logic sel);
    if (sel) return 193;
    case (variant)
      0, 1:    return 256;
      default: return 512;
    endcase
  endfunction

  function automatic fs_mode_t fs_mode(input int variant, input logic sel);
    fs_mode_t m;
    int r;
    int n;
    r = fs_ratio(variant, sel);
    n = fs_frame_len(variant, sel);
    m.div_last = FS_DIV_W'(r - 1);
    m.high_len = FS_DIV_W'((r + 1) / 2);
    m.frm_last = FS_FRM_W'(n - 1);
    return m;
  endfunction

endpackage

// File: rtl/fs_sync_capture.sv
module fs_sync_capture #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_in,
  input  logic clk_hi,
  input  logic rst_n,
  input  logic syncin,
  output logic align
);

  logic              samp_q;
  logic [SYNC_STAGES:0] chain_q;

  // Sample on the input-rate clock
  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) samp_q <= 1'b0;
    else        samp_q <= syncin;
  end

  // Synchronizer stages plus one history stage for edge detection
  always_ff @(posedge clk_hi or negedge rst_n) begin
    if (!rst_n) chain_q[0] <= 1'b0;
    else        chain_q[0] <= samp_q;
  end

  for (genvar i = 1; i <= SYNC_STAGES; i++) begin : g_stage
    always_ff @(posedge clk_hi or negedge rst_n) begin
      if (!rst_n) chain_q[i] <= 1'b0;
      else        chain_q[i] <= chain_q[i-1];
    end
  end

  assign align = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];

  // R5
  align_pulse_chk: assert property (@(posedge clk_hi) disable iff (!rst_n)
    align |=> !align);

endmodule

// File: rtl/fs_carrier_div.sv
module fs_carrier_div
  import frsync_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                restart,
  input  logic [FS_DIV_W-1:0] div_last,
  input  logic [FS_DIV_W-1:0] high_len,
  output logic [FS_DIV_W-1:0] cnt,
  output logic                wrap,
  output logic                clk_out
);

  logic [FS_DIV_W-1:0] cnt_q;
  logic [FS_DIV_W-1:0] cnt_nxt;
  logic                clk_q;

  assign wrap = (cnt_q == div_last);

  always_comb begin
    if (restart || wrap) cnt_nxt = '0;
    else                 cnt_nxt = cnt_q + 1'b1;
  end

  // Output registered from the next phase so it is glitch free
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      clk_q <= 1'b1;
    end else begin
      cnt_q <= cnt_nxt;
      clk_q <= (cnt_nxt < high_len);
    end
  end

  assign cnt     = cnt_q;
  assign clk_out = clk_q;

  // R9
  div_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |-> (cnt_q <= div_last));

  // R3
  div_wrap_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && wrap) |=> clk_q);

endmodule

// File: rtl/fs_frame_ctr.sv
module fs_frame_ctr
  import frsync_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                restart,
  input  logic                step,
  input  logic [FS_FRM_W-1:0] frm_last,
  output logic [FS_FRM_W-1:0] fcnt,
  output logic                sync_out
);

  logic [FS_FRM_W-1:0] f_q;
  logic [FS_FRM_W-1:0] f_nxt;
  logic                sy_q;

  always_comb begin
    if (restart)                 f_nxt = '0;
    else if (step && f_q == frm_last) f_nxt = '0;
    else if (step)               f_nxt = f_q + 1'b1;
    else                         f_nxt = f_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_q  <= '0;
      sy_q <= 1'b1;
    end else begin
      f_q  <= f_nxt;
      sy_q <= (f_nxt == '0);
    end
  end

  assign fcnt     = f_q;
  assign sync_out = sy_q;

  // R9
  frm_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |-> (f_q <= frm_last));

endmodule

// File: rtl/frsync_gen.sv
module frsync_gen
  import frsync_pkg::*;
#(
  parameter int VARIANT     = 0,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_hi,
  input  logic clk_in,
  input  logic rst_n,
  input  logic sel,
  input  logic syncin,
  output logic clkout1,
  output logic syncout
);

  fs_mode_t            mode;
  logic                align;
  logic                sel_q;
  logic                sel_chg;
  logic                restart;
  logic [FS_DIV_W-1:0] div_cnt;
  logic                div_wrap;
  logic [FS_FRM_W-1:0] frm_cnt;

  always_comb mode = fs_mode(VARIANT, sel);

  always_ff @(posedge clk_hi or negedge rst_n) begin
    if (!rst_n) sel_q <= 1'b0;
    else        sel_q <= sel;
  end

  assign sel_chg = sel ^ sel_q;
  assign restart = align | sel_chg;

  fs_sync_capture #(.SYNC_STAGES(SYNC_STAGES)) u_cap (
    .clk_in (clk_in),
    .clk_hi (clk_hi),
    .rst_n  (rst_n),
    .syncin (syncin),
    .align  (align)
  );

  fs_carrier_div u_div (
    .clk      (clk_hi),
    .rst_n    (rst_n),
    .restart  (restart),
    .div_last (mode.div_last),
    .high_len (mode.high_len),
    .cnt      (div_cnt),
    .wrap     (div_wrap),
    .clk_out  (clkout1)
  );

  fs_frame_ctr u_frm (
    .clk      (clk_hi),
    .rst_n    (rst_n),
    .restart  (restart),
    .step     (div_wrap),
    .frm_last (mode.frm_last),
    .fcnt     (frm_cnt),
    .sync_out (syncout)
  );

  // R5
  realign_chk: assert property (@(posedge clk_hi) disable iff (!rst_n)
    align |=> (div_cnt == '0 && frm_cnt == '0 && clkout1 && syncout));

  // R8
  selchg_chk: assert property (@(posedge clk_hi) disable iff (!rst_n)
    sel_chg |=> (div_cnt == '0 && frm_cnt == '0));

  // R4
  sync_phase_chk: assert property (@(posedge clk_hi) disable iff (!rst_n)
    $rose(syncout) |-> clkout1);

endmodule

// File: tb/frsync_gen_test.sv
module frsync_gen_test;

  logic  clk_hi = 1'b0;
  logic  clk_in = 1'b0;
  logic  rst_n  = 1'b0;
  logic  sel    = 1'b0;
  logic  syncin = 1'b0;
  int    n_cmp  = 0;
  int    n_bad  = 0;
  string tag    = "R1";
  bit    chk_en = 1'b0;
  bit    free_phase = 1'b0;
  bit    reported = 1'b0;

  // 250 MHz
  always #2 clk_hi = ~clk_hi;

  // clk_in at a quarter rate, rising halfway between clk_hi rising edges
  initial begin
    #4;
    forever begin
      clk_in = 1'b1;
      #8;
      clk_in = 1'b0;
      #8;
    end
  end

  function automatic int exp_ratio(input int v, input logic s);
    if (s) return 4;
    if (v == 0) return 3;
    if (v == 1) return 4;
    return 2;
  endfunction

  function automatic int exp_len(input int v, input logic s);
    if (s) return 193;
    if (v == 2) return 512;
    return 256;
  endfunction

  task automatic note_fail(input string req, input int v, input string what,
                           input int got, input int exp);
    n_bad++;
    $display("FAIL %s variant %0d %s: actual %0d expected %0d at %0t",
             req, v, what, got, exp, $time);
  endtask

  for (genvar v = 0; v < 3; v++) begin : g_var
    logic ck;
    logic sy;
    int   hi_edges = 0;
    int   due = -1;
    int   md = 0;
    int   mf = 0;
    logic sprev = 1'b0;
    logic selp = 1'b0;
    logic exp_ck = 1'b1;
    logic exp_sy = 1'b1;

    frsync_gen #(.VARIANT(v)) uut (
      .clk_hi  (clk_hi),
      .clk_in  (clk_in),
      .rst_n   (rst_n),
      .sel     (sel),
      .syncin  (syncin),
      .clkout1 (ck),
      .syncout (sy)
    );

    // R5: restart is due on the third clk_hi edge after the sampling clk_in edge
    always @(posedge clk_in or negedge rst_n) begin
      if (!rst_n) begin
        sprev = 1'b0;
        due   = -1;
      end else begin
        if (syncin && !sprev) due = hi_edges + 3;
        sprev = syncin;
      end
    end

    always @(posedge clk_hi) begin
      int  r;
      int  n;
      bit  rs;
      hi_edges++;
      if (!rst_n) begin
        md = 0; mf = 0; selp = 1'b0;
      end else begin
        r  = exp_ratio(v, sel);
        n  = exp_len(v, sel);
        rs = (hi_edges == due) || (sel != selp);
        selp = sel;
        if (rs) begin
          md = 0; mf = 0;
        end else if (md == r - 1) begin
          md = 0;
          mf = (mf == n - 1) ? 0 : mf + 1;
        end else begin
          md++;
        end
      end
      exp_ck = (md < (exp_ratio(v, sel) + 1) / 2);
      exp_sy = (mf == 0);
    end

    always @(negedge clk_hi) begin
      if (chk_en) begin
        n_cmp++;
        if (ck !== exp_ck || sy !== exp_sy) begin
          n_bad++;
          $display("FAIL %s variant %0d clkout1/syncout: actual %b%b expected %b%b at %0t",
                   tag, v, ck, sy, exp_ck, exp_sy, $time);
        end
      end
    end

    // Period and width measurement during free-running stretches (R3, R4)
    int   sy_int = 0, sy_w = 0, ck_int = 0, ck_w = 0;
    bit   sy_seen = 0, ck_seen = 0;
    logic psy = 1'b0, pck = 1'b0;
    always @(negedge clk_hi) begin
      int r;
      int n;
      r = exp_ratio(v, sel);
      n = exp_len(v, sel);
      if (!free_phase) begin
        sy_seen = 0; ck_seen = 0;
      end else begin
        sy_int++; ck_int++;
        if (sy && !psy) begin
          if (sy_seen) begin
            n_cmp++;
            if (sy_int != r * n) note_fail("R4", v, {tag, " frame period"}, sy_int, r * n);
          end
          sy_seen = 1; sy_int = 0; sy_w = 1;
        end else if (sy) sy_w++;
        if (!sy && psy && sy_seen) begin
          n_cmp++;
          if (sy_w != r) note_fail("R4", v, {tag, " syncout width"}, sy_w, r);
        end
        if (ck && !pck) begin
          if (ck_seen) begin
            n_cmp++;
            if (ck_int != r) note_fail("R3", v, {tag, " clkout1 period"}, ck_int, r);
          end
          ck_seen = 1; ck_int = 0; ck_w = 1;
        end else if (ck) ck_w++;
        if (!ck && pck && ck_seen) begin
          n_cmp++;
          if (ck_w != (r + 1) / 2) note_fail("R3", v, {tag, " clkout1 high"}, ck_w, (r + 1) / 2);
        end
      end
      psy = sy;
      pck = ck;
    end
  end

  task automatic hi(input int n);
    repeat (n) @(negedge clk_hi);
  endtask

  task automatic pulse_sync(input int w);
    @(negedge clk_in);
    syncin = 1'b1;
    repeat (w) @(negedge clk_in);
    syncin = 1'b0;
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_hi);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    report();
  end

  initial begin
    void'($urandom(32'd4711));
    // R1: reset state
    tag = "R1";
    hi(3);
    chk_en = 1'b1;
    hi(4);
    @(negedge clk_hi) rst_n = 1'b1;
    hi(2);

    // R3 / R4 / R2: free run with sel=0
    tag = "R3";
    free_phase = 1'b1;
    hi(2600);
    free_phase = 1'b0;

    // R5: directed realignments of different widths
    tag = "R5";
    pulse_sync(1);
    hi(200);
    pulse_sync(2);
    hi(900);

    // R6: syncin held high, then low
    tag = "R6";
    @(negedge clk_in) syncin = 1'b1;
    hi(20);
    free_phase = 1'b1;
    hi(2600);
    free_phase = 1'b0;
    @(negedge clk_in) syncin = 1'b0;
    hi(20);

    // R8: mode change, then R2 free run with sel=1
    tag = "R8";
    @(negedge clk_hi) sel = 1'b1;
    hi(37);
    tag = "R2";
    free_phase = 1'b1;
    hi(2000);
    free_phase = 1'b0;

    // R7: sub-rate sync, one edge every two 772-cycle frames
    tag = "R7";
    pulse_sync(1);
    repeat (384) @(negedge clk_in);
    free_phase = 1'b1;
    repeat (4) begin
      pulse_sync(1);
      repeat (384) @(negedge clk_in);
    end
    free_phase = 1'b0;

    // Random mix of realignments and mode changes (R5, R8)
    for (int i = 0; i < 40; i++) begin
      hi($urandom_range(1200, 30));
      if ($urandom_range(3, 0) == 0) begin
        tag = "R8";
        @(negedge clk_hi) sel = ~sel;
      end else begin
        tag = "R5";
        pulse_sync($urandom_range(3, 1));
      end
    end

    // R9: settle and free run after arbitrary restarts
    tag = "R9";
    hi(20);
    free_phase = 1'b1;
    hi(3000);
    free_phase = 1'b0;
    hi(4);
    report();
  end

endmodule